// File: doc/BRIEF.md
# Cross-Domain Block Transfer Sequencer

This block copies a fixed block of 256 words from a read-only source memory in one clock domain into a writable destination memory in a second clock domain. Two independent state machines sit on either side of a dual-clock FIFO that lives outside the block. The source-side machine walks the source address and issues FIFO pushes, and it pauses whenever the FIFO reports full. The destination-side machine pops the FIFO, advances the destination address, strobes the destination write and read enables, and counts the words it has stored.

The source side has five states. `WR_IDLE` waits for room. `WR_WRITE` pushes the word at the current address. `WR_INCADR` drops the push and steps the address. `WR_WAIT` holds the address while the FIFO is full. `WR_DONE` is reached after the push at the last address. Its transitions are: IDLE→WRITE on not-full, WRITE→INCADR when the address is not the last one, WRITE→DONE at the last address, INCADR→WRITE on not-full, INCADR→WAIT on full, and WAIT→WRITE once full clears. The destination side has three states. `RD_IDLE` waits while the FIFO is empty. `RD_INCADR` pops and steps the address. `RD_WRITE` stores and counts. Its transitions are: IDLE→INCADR on not-empty, INCADR→WRITE unconditionally, WRITE→INCADR on not-empty, and WRITE→IDLE on empty.

The destination address starts at all ones and is stepped before each store, so the first word lands at address 0. The FIFO returns a popped word one destination clock after the pop, which is the cycle in which the store enable is high.

Top module: `rom_ram_xfer`

## Requirements
- R1: While `src_rst_n` is low, the source side is in WR_IDLE with `fifo_wr` low and `src_addr` equal to 0.
- R2: The source side leaves WR_IDLE only when `fifo_full` was low at the clock edge. `fifo_wr` is high for exactly one cycle per WR_WRITE, and `src_addr` is held through that cycle and the one after it.
- R3: The source address changes only in WR_INCADR and only by +1, so pushes carry the addresses 0, 1, 2, … in order.
- R4: When `fifo_full` is seen in WR_INCADR, the source side enters WR_WAIT. It keeps `src_addr` and `fifo_wr` low until full is seen low, then goes to WR_WRITE. A push is never issued in a cycle whose preceding edge saw `fifo_full` high.
- R5: The push at address 255 (all ones) is the last one. The source side then stays in WR_DONE with `fifo_wr` low and `src_addr` at 255, for 256 pushes in total.
- R6: After reset, and while `fifo_empty` is high, the destination side idles with `dst_addr` = 255, `word_cnt` = 0 and `fifo_rd`, `dst_we`, `dst_re` all low.
- R7: In RD_INCADR, `fifo_rd` is high and `dst_addr` advances by one with 255 wrapping to 0. RD_WRITE always follows in the next cycle.
- R8: In RD_WRITE, `dst_we` and `dst_re` are both high for one cycle and `word_cnt` increments by one. The next state is RD_INCADR if `fifo_empty` is low, otherwise RD_IDLE with `dst_addr` held.
- R9: After a full transfer, `word_cnt` reads 256, the first store used address 0, the last store used address 255, and every destination word equals the source word at the same address.
- R10: `fifo_rd` is low in every cycle in which `fifo_empty` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source-domain clock |
| src_rst_n | input | 1 | Source-domain asynchronous reset, active low |
| fifo_full | input | 1 | FIFO full flag, source domain |
| src_addr | output | ADDR_W (8) | Source memory address |
| fifo_wr | output | 1 | FIFO push request |
| dst_clk | input | 1 | Destination-domain clock |
| dst_rst_n | input | 1 | Destination-domain asynchronous reset, active low |
| fifo_empty | input | 1 | FIFO empty flag, destination domain |
| fifo_rd | output | 1 | FIFO pop request |
| dst_addr | output | ADDR_W (8) | Destination memory address |
| dst_we | output | 1 | Destination memory write enable |
| dst_re | output | 1 | Destination memory read enable |
| word_cnt | output | ADDR_W+1 (9) | Number of words stored |

## Verification
The bound checker watches the local stepping rules on every cycle. These are: single-cycle pushes with the address held around them, address and count steps of exactly one, no push after an edge that saw full, a pop always followed by a store, and a quiet source side after the final push. Only the bench scenarios can show the sequence-level results. These are the stall in WR_WAIT with the address parked at 8 behind a forced-full FIFO, idling behind a forced-empty flag, the exact order of store addresses starting at 0, the 256-word total, and the data that arrives in the destination memory.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    typedef enum logic [2:0] {
        WR_IDLE,
        WR_WRITE,
        WR_INCADR,
        WR_WAIT,
        WR_DONE
    } wr_state_e;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_INCADR,
        RD_WRITE
    } rd_state_e;

endpackage

// File: rtl/xfer_wr_seq.sv
module xfer_wr_seq
    import xfer_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              full,
    output logic [ADDR_W-1:0] addr,
    output logic              push
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
    localparam logic [ADDR_W-1:0] ADDR_ONE  = ADDR_W'(1);

    wr_state_e state_q;
    wr_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // address register: steps only on leaving WR_INCADR
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (state_q == WR_INCADR) begin
            addr <= addr + ADDR_ONE;
        end
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE:   if (!full) state_d = WR_WRITE;
            WR_WRITE:  state_d = (addr == LAST_ADDR) ? WR_DONE : WR_INCADR;
            WR_INCADR: state_d = full ? WR_WAIT : WR_WRITE;
            WR_WAIT:   if (!full) state_d = WR_WRITE;
            WR_DONE:   state_d = WR_DONE;
            default:   state_d = WR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        push = 1'b0;
        unique case (state_q)
            WR_WRITE: push = 1'b1;
            default:  push = 1'b0;
        endcase
    end

endmodule

// File: rtl/xfer_rd_seq.sv
module xfer_rd_seq
    import xfer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              empty,
    output logic              pop,
    output logic [ADDR_W-1:0] addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [CNT_W-1:0]  count
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

    rd_state_e state_q;
    rd_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // address: starts at all ones, steps (with wrap) on leaving RD_INCADR
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '1;
        end else if (state_q == RD_INCADR) begin
            addr <= addr + ADDR_ONE;
        end
    end

    // stored-word counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (state_q == RD_WRITE) begin
            count <= count + CNT_ONE;
        end
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE:   if (!empty) state_d = RD_INCADR;
            RD_INCADR: state_d = RD_WRITE;
            RD_WRITE:  state_d = empty ? RD_IDLE : RD_INCADR;
            default:   state_d = RD_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pop    = 1'b0;
        mem_we = 1'b0;
        mem_re = 1'b0;
        unique case (state_q)
            RD_INCADR: pop = !empty;
            RD_WRITE: begin
                mem_we = 1'b1;
                mem_re = 1'b1;
            end
            default: begin
                pop    = 1'b0;
                mem_we = 1'b0;
                mem_re = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rom_ram_xfer.sv
module rom_ram_xfer #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = ADDR_W + 1
) (
    input  logic              src_clk,
    input  logic              src_rst_n,
    input  logic              fifo_full,
    output logic [ADDR_W-1:0] src_addr,
    output logic              fifo_wr,
    input  logic              dst_clk,
    input  logic              dst_rst_n,
    input  logic              fifo_empty,
    output logic              fifo_rd,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              dst_we,
    output logic              dst_re,
    output logic [CNT_W-1:0]  word_cnt
);

    xfer_wr_seq #(
        .ADDR_W (ADDR_W)
    ) u_wr (
        .clk   (src_clk),
        .rst_n (src_rst_n),
        .full  (fifo_full),
        .addr  (src_addr),
        .push  (fifo_wr)
    );

    xfer_rd_seq #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_rd (
        .clk    (dst_clk),
        .rst_n  (dst_rst_n),
        .empty  (fifo_empty),
        .pop    (fifo_rd),
        .addr   (dst_addr),
        .mem_we (dst_we),
        .mem_re (dst_re),
        .count  (word_cnt)
    );

endmodule

// File: rtl/rom_ram_xfer_chk.sv
module rom_ram_xfer_chk #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = ADDR_W + 1
) (
    input logic              src_clk,
    input logic              src_rst_n,
    input logic              fifo_full,
    input logic [ADDR_W-1:0] src_addr,
    input logic              fifo_wr,
    input logic              dst_clk,
    input logic              dst_rst_n,
    input logic              fifo_empty,
    input logic              fifo_rd,
    input logic [ADDR_W-1:0] dst_addr,
    input logic              dst_we,
    input logic              dst_re,
    input logic [CNT_W-1:0]  word_cnt
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    p_push_single_r2: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        fifo_wr |=> !fifo_wr);

    p_push_addr_hold_r2: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        fifo_wr |=> $stable(src_addr));

    p_src_step_r3: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        !$stable(src_addr) |-> (src_addr == ADDR_W'($past(src_addr) + 1'b1)));

    p_no_push_after_full_r4: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        fifo_wr |-> !$past(fifo_full));

    p_final_push_r5: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (fifo_wr && src_addr == LAST_ADDR) |=> (!fifo_wr && src_addr == LAST_ADDR));

    p_pop_then_store_r7: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        fifo_rd |=> (dst_we && dst_re));

    p_dst_step_r7: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        !$stable(dst_addr) |-> (dst_addr == ADDR_W'($past(dst_addr) + 1'b1)));

    p_store_single_r8: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        dst_we |=> !dst_we);

    p_count_step_r8: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        !$stable(word_cnt) |-> ($past(dst_we) && word_cnt == CNT_W'($past(word_cnt) + 1'b1)));

endmodule

bind rom_ram_xfer rom_ram_xfer_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .src_clk    (src_clk),
    .src_rst_n  (src_rst_n),
    .fifo_full  (fifo_full),
    .src_addr   (src_addr),
    .fifo_wr    (fifo_wr),
    .dst_clk    (dst_clk),
    .dst_rst_n  (dst_rst_n),
    .fifo_empty (fifo_empty),
    .fifo_rd    (fifo_rd),
    .dst_addr   (dst_addr),
    .dst_we     (dst_we),
    .dst_re     (dst_re),
    .word_cnt   (word_cnt)
);

// File: tb/sim_rom_ram_xfer.sv
module sim_rom_ram_xfer;

    localparam int AW    = 8;
    localparam int CW    = AW + 1;
    localparam int WORDS = 1 << AW;
    localparam int NPROBE = 8;
    localparam int PROBE [NPROBE] = '{0, 1, 2, 85, 127, 128, 254, 255};

    logic src_clk = 1'b0;
    logic dst_clk = 1'b0;
    logic src_rst_n = 1'b0;
    logic dst_rst_n = 1'b0;
    logic force_full = 1'b1;
    logic force_empty = 1'b1;

    logic          fifo_full, fifo_empty;
    logic [AW-1:0] src_addr, dst_addr;
    logic          fifo_wr, fifo_rd, dst_we, dst_re;
    logic [CW-1:0] word_cnt;

    int n_checks = 0;
    int n_fails  = 0;

    always #4  src_clk = ~src_clk;
    always #10 dst_clk = ~dst_clk;

    function automatic logic [7:0] pattern(input int a);
        return 8'((a * 29 + 7) ^ 8'h5A);
    endfunction

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // behavioural dual-clock FIFO, depth 8, with guarded push/pop
    logic [7:0] fmem [8];
    logic [3:0] wp = '0, rp = '0, rp_s1 = '0, rp_s2 = '0, wp_d1 = '0, wp_d2 = '0;
    logic [7:0] fq = '0;
    int         accepted = 0;
    logic       full_m, empty_m;

    assign full_m     = ((wp - rp_s2) == 4'd8);
    assign empty_m    = (wp_d2 == rp);
    assign fifo_full  = full_m | force_full;
    assign fifo_empty = empty_m | force_empty;

    always @(posedge src_clk) begin
        if (fifo_wr && !full_m) begin
            fmem[wp[2:0]] <= pattern(int'(src_addr));
            wp <= wp + 4'd1;
            accepted <= accepted + 1;
        end
        rp_s1 <= rp;
        rp_s2 <= rp_s1;
    end

    always @(posedge dst_clk) begin
        if (fifo_rd && !empty_m) begin
            fq <= fmem[rp[2:0]];
            rp <= rp + 4'd1;
        end
        wp_d1 <= wp;
        wp_d2 <= wp_d1;
    end

    // destination memory
    logic [7:0] dmem [WORDS];
    always @(posedge dst_clk) begin
        if (dst_we) dmem[dst_addr] <= fq;
    end

    rom_ram_xfer #(.ADDR_W(AW)) u0 (
        .src_clk    (src_clk),
        .src_rst_n  (src_rst_n),
        .fifo_full  (fifo_full),
        .src_addr   (src_addr),
        .fifo_wr    (fifo_wr),
        .dst_clk    (dst_clk),
        .dst_rst_n  (dst_rst_n),
        .fifo_empty (fifo_empty),
        .fifo_rd    (fifo_rd),
        .dst_addr   (dst_addr),
        .dst_we     (dst_we),
        .dst_re     (dst_re),
        .word_cnt   (word_cnt)
    );

    // source-side monitor
    int   exp_waddr = 0;
    int   n_push = 0;
    logic prev_wr = 1'b0;
    always @(negedge src_clk) begin
        if (src_rst_n) begin
            if (fifo_wr) begin
                chk(!prev_wr, "R2 back-to-back push", 1, 0);
                chk(!force_full, "R2 push while held full", 1, 0);
                chk(n_push < WORDS, "R5 push after final", n_push, WORDS - 1);
                chk(int'(src_addr) == exp_waddr, "R3 push address", src_addr, exp_waddr);
                exp_waddr++;
                n_push++;
            end
            prev_wr <= fifo_wr;
        end
    end

    // destination-side monitor
    int exp_daddr = 0;
    int n_store = 0;
    int first_store = -1;
    int last_store = -1;
    always @(negedge dst_clk) begin
        if (dst_rst_n) begin
            if (fifo_rd && fifo_empty) chk(1'b0, "R10 pop while empty", 1, 0);
            if (dst_we != dst_re) chk(1'b0, "R8 we/re pair", dst_re, dst_we);
            if (dst_we) begin
                chk(int'(dst_addr) == (exp_daddr % WORDS), "R7 store address", dst_addr, exp_daddr % WORDS);
                chk(int'(word_cnt) == n_store, "R8 count before store", word_cnt, n_store);
                if (first_store < 0) first_store = int'(dst_addr);
                last_store = int'(dst_addr);
                exp_daddr++;
                n_store++;
            end
        end
    end

    // watchdog
    initial begin
        #1_500_000;
        n_fails++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        int a1;
        int bad;
        repeat (5) @(negedge src_clk);
        // R1 / R6: values during reset
        chk(src_addr == 0, "R1 reset src_addr", src_addr, 0);
        chk(fifo_wr == 0, "R1 reset fifo_wr", fifo_wr, 0);
        chk(dst_addr == 8'hFF, "R6 reset dst_addr", dst_addr, 255);
        chk(word_cnt == 0, "R6 reset word_cnt", word_cnt, 0);
        chk(!fifo_rd && !dst_we && !dst_re, "R6 reset read strobes", fifo_rd, 0);

        src_rst_n <= 1'b1;
        dst_rst_n <= 1'b1;
        repeat (30) @(negedge src_clk);
        // R2: held full keeps the source side idle
        chk(n_push == 0, "R2 no push while full", n_push, 0);
        chk(src_addr == 0, "R2 address parked", src_addr, 0);
        // R6: held empty keeps the destination side idle
        chk(dst_addr == 8'hFF, "R6 idle dst_addr", dst_addr, 255);
        chk(word_cnt == 0, "R6 idle word_cnt", word_cnt, 0);

        force_full <= 1'b0;
        repeat (60) @(negedge src_clk);
        // R4: FIFO fills with 8 words, address parked at 8 in WAIT
        a1 = int'(src_addr);
        chk(accepted == 8, "R4 words accepted before stall", accepted, 8);
        chk(a1 == 8, "R4 parked address", a1, 8);
        repeat (20) @(negedge src_clk);
        chk(int'(src_addr) == a1, "R4 address held in wait", src_addr, a1);
        chk(n_push == 8, "R4 no push while full", n_push, 8);
        chk(n_store == 0, "R6 no store while empty", n_store, 0);

        force_empty <= 1'b0;
        for (int i = 0; i < 20000 && word_cnt != CW'(WORDS); i++) @(negedge dst_clk);
        repeat (40) @(negedge dst_clk);

        chk(word_cnt == CW'(WORDS), "R9 final count", word_cnt, WORDS);
        chk(first_store == 0, "R9 first store address", first_store, 0);
        chk(last_store == WORDS - 1, "R9 last store address", last_store, WORDS - 1);
        chk(n_push == WORDS, "R5 total pushes", n_push, WORDS);
        chk(accepted == WORDS, "R5 pushes accepted", accepted, WORDS);
        chk(src_addr == 8'hFF && !fifo_wr, "R5 quiet after final", src_addr, 255);
        chk(dst_addr == 8'hFF && !fifo_rd && !dst_we, "R8 idle after drain", dst_addr, 255);

        // R9: probe table then full sweep of destination contents
        for (int k = 0; k < NPROBE; k++) begin
            chk(dmem[PROBE[k]] == pattern(PROBE[k]), "R9 probe data", dmem[PROBE[k]], pattern(PROBE[k]));
        end
        bad = 0;
        for (int a = 0; a < WORDS; a++) begin
            if (dmem[a] != pattern(a)) bad++;
        end
        chk(bad == 0, "R9 destination sweep", bad, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule